// File: doc/BRIEF.md
# Block-Mode Memory DMA Channel

This block is one DMA channel that copies a block of 32-bit words between main memory and a peripheral data port. Software programs three registers through a simple register port: a start address, a block word (two 16-bit halves whose product is the word count) and a control word. Writing the control register with the start bit set launches a transfer. Only two exact control values start a transfer, one for each direction. Every other value that has the start bit set finishes at once, with no data movement.

While running, the channel drives single-cycle word reads or writes on a memory port. It exchanges words with the peripheral over a valid/ready pair, and only a completed handshake moves a word. The length is clipped so that the transfer never runs past the last valid memory word. When the channel finishes, the address register holds the address that follows the last word moved, the busy bit drops, and the interrupt output pulses for one cycle.

Top module: `dma_block_chan`

## Requirements
- R1: After reset the address, block and control registers read zero, `irq` is low, and `mem_en`, `tx_valid` and `rx_ready` stay low while the channel is idle.
- R2: While idle, writes with `reg_sel` 0 (address), 1 (block) and 2 (control) are stored and read back unchanged on `reg_rdata`. Selector 3 reads zero.
- R3: Control value 0x01000201 moves words from memory to the peripheral. The word count is block[31:16] times block[15:0]. Words are read from consecutive word addresses and presented on `tx_data` in ascending order.
- R4: On a valid start, bits [1:0] of the address register are cleared before the first word is moved.
- R5: Control value 0x01000200 moves words from the peripheral to memory. Each accepted `rx_data` word is written to the next ascending word address.
- R6: The address and the remaining count change only on a cycle in which the peripheral handshake completes. While the handshake is stalled, `mem_addr` and `tx_data` hold steady.
- R7: Bit 24 of the control register reads as 1 throughout a running transfer. It clears on the edge that moves the last word, and `irq` is high for exactly that following cycle.
- R8: A control write with bit 24 set and any other value stores the value with bit 24 cleared, moves no data, and pulses `irq` once in the cycle after the write. A control write with bit 24 clear starts nothing and raises no interrupt.
- R9: At completion the address register reads the aligned start address plus four times the number of words moved.
- R10: The word count is clipped to MEM_WORDS minus the start word index. If the start lies at or beyond the end of memory, no word moves and the channel completes at once. `mem_en` never addresses a word at or above MEM_WORDS.
- R11: Register writes that arrive while the channel is busy are ignored.
- R12: A valid start with either block half equal to zero moves no data and completes at once with one `irq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 block, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (otherwise read) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| tx_valid | output | 1 | Word offered to the peripheral |
| tx_ready | input | 1 | Peripheral accepts the offered word |
| tx_data | output | 32 | Word to the peripheral |
| rx_valid | input | 1 | Peripheral offers a word |
| rx_ready | output | 1 | Channel accepts the offered word |
| rx_data | input | 32 | Word from the peripheral |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a transfer that is stalled mid-stream while software tries to rewrite the registers. Register writes only matter when they land inside a window that the peripheral handshake controls. The bench holds `tx_ready` low after a start so the channel waits on its first word. It then checks that the address and output data stay fixed, writes the address register, and reads it back unchanged before releasing the handshake. The table runs also alternate irregular stall patterns on both directions, and one run starts near the top of a reduced memory so that clipping cuts the transfer short.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int          REG_W     = 32;
    localparam int          HALF_W    = 16;
    localparam int          BUSY_BIT  = 24;
    localparam logic [31:0] CTRL_M2P  = 32'h0100_0201;
    localparam logic [31:0] CTRL_P2M  = 32'h0100_0200;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_BLOCK = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] blk;
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] left;
        logic             irq;
    } chan_state_t;

endpackage

// File: rtl/dma_len_calc.sv
module dma_len_calc
    import dma_chan_pkg::*;
#(
    parameter int MEM_WORDS = 524288
) (
    input  logic [2*HALF_W-1:0] blk_i,
    input  logic [REG_W-1:0]    start_i,
    output logic [REG_W-1:0]    words_o
);
    localparam int               CNT_W = 2 * HALF_W;
    localparam logic [REG_W-1:0] LIMIT = REG_W'(MEM_WORDS);

    logic [CNT_W-1:0] req;
    logic [REG_W-1:0] start_word;
    logic [REG_W-1:0] room;

    always_comb begin
        req        = CNT_W'(blk_i[CNT_W-1:HALF_W]) * CNT_W'(blk_i[HALF_W-1:0]);
        start_word = {2'b00, start_i[REG_W-1:2]};
        room       = (start_word < LIMIT) ? (LIMIT - start_word) : '0;
        words_o    = (REG_W'(req) < room) ? REG_W'(req) : room;
    end

endmodule

// File: rtl/dma_port_mux.sv
module dma_port_mux
    import dma_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             to_periph_i,
    input  logic [REG_W-1:0] cur_addr_i,
    output logic             beat_o,
    output logic             mem_en,
    output logic             mem_we,
    output logic [REG_W-1:0] mem_addr,
    output logic [REG_W-1:0] mem_wdata,
    input  logic [REG_W-1:0] mem_rdata,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [REG_W-1:0] tx_data,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [REG_W-1:0] rx_data
);
    logic out_dir;
    logic in_dir;

    always_comb begin
        out_dir   = run_i && to_periph_i;
        in_dir    = run_i && !to_periph_i;
        tx_valid  = out_dir;
        tx_data   = mem_rdata;
        rx_ready  = in_dir;
        mem_wdata = rx_data;
        mem_addr  = cur_addr_i;
        mem_we    = in_dir && rx_valid;
        mem_en    = out_dir || (in_dir && rx_valid);
        beat_o    = (out_dir && tx_ready) || (in_dir && rx_valid);
    end

    // R3/R5: the two directions never offer or accept at the same time
    p_dir_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));

    // R5: a memory write only happens on an accepted peripheral word
    p_write_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (rx_valid && rx_ready && mem_en));

endmodule

// File: rtl/dma_block_chan.sv
module dma_block_chan
    import dma_chan_pkg::*;
#(
    parameter int MEM_WORDS = 524288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mem_en,
    output logic             mem_we,
    output logic [REG_W-1:0] mem_addr,
    output logic [REG_W-1:0] mem_wdata,
    input  logic [REG_W-1:0] mem_rdata,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [REG_W-1:0] tx_data,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [REG_W-1:0] rx_data,
    output logic             irq
);
    localparam logic [REG_W-1:0] LIMIT = REG_W'(MEM_WORDS);

    chan_state_t      s_d, s_q;
    logic             busy;
    logic             beat;
    logic [REG_W-1:0] aligned_addr;
    logic [REG_W-1:0] start_words;
    logic             valid_start;
    reg_sel_e         sel;

    assign sel          = reg_sel_e'(reg_sel);
    assign busy         = s_q.ctrl[BUSY_BIT];
    assign aligned_addr = {s_q.addr[REG_W-1:2], 2'b00};
    assign valid_start  = (reg_wdata == CTRL_M2P) || (reg_wdata == CTRL_P2M);
    assign irq          = s_q.irq;

    dma_len_calc #(
        .MEM_WORDS (MEM_WORDS)
    ) u_len (
        .blk_i   (s_q.blk),
        .start_i (aligned_addr),
        .words_o (start_words)
    );

    dma_port_mux u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (busy),
        .to_periph_i (s_q.ctrl[0]),
        .cur_addr_i  (s_q.addr),
        .beat_o      (beat),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_data     (tx_data),
        .rx_valid    (rx_valid),
        .rx_ready    (rx_ready),
        .rx_data     (rx_data)
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (busy) begin
            if (beat) begin
                s_d.addr = s_q.addr + REG_W'(4);
                s_d.left = s_q.left - REG_W'(1);
                if (s_q.left == REG_W'(1)) begin
                    s_d.ctrl[BUSY_BIT] = 1'b0;
                    s_d.irq            = 1'b1;
                end
            end
        end else if (reg_wr) begin
            unique case (sel)
                SEL_ADDR:  s_d.addr = reg_wdata;
                SEL_BLOCK: s_d.blk  = reg_wdata;
                SEL_CTRL: begin
                    s_d.ctrl = reg_wdata;
                    if (reg_wdata[BUSY_BIT]) begin
                        if (valid_start) begin
                            s_d.addr = aligned_addr;
                            s_d.left = start_words;
                            if (start_words == '0) begin
                                s_d.ctrl[BUSY_BIT] = 1'b0;
                                s_d.irq            = 1'b1;
                            end
                        end else begin
                            s_d.ctrl[BUSY_BIT] = 1'b0;
                            s_d.irq            = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ADDR:  reg_rdata = s_q.addr;
            SEL_BLOCK: reg_rdata = s_q.blk;
            SEL_CTRL:  reg_rdata = s_q.ctrl;
            default:   reg_rdata = '0;
        endcase
    end

    // R1: an idle channel touches neither memory nor the peripheral
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_en && !tx_valid && !rx_ready));

    // R6: a stalled handshake leaves the address and count untouched
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat) |=> ($stable(s_q.addr) && $stable(s_q.left)));

    // R7: the busy bit only drops together with the interrupt pulse
    p_fall_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    // R7: while the interrupt is high the busy bit already reads clear
    p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

    // R9: every moved word advances the address by one word
    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat) |=> (s_q.addr == $past(s_q.addr) + REG_W'(4)));

    // R10: no access reaches past the end of memory
    p_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> ({2'b00, mem_addr[REG_W-1:2]} < LIMIT));

    // R11: the block register is frozen while busy
    p_busy_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> $stable(s_q.blk));

endmodule

// File: tb/dma_block_chan_tb.sv
module dma_block_chan_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MEMW       = 64;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] blk;
        logic [31:0] ctrl;
        logic [31:0] words;
        logic [31:0] end_addr;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{32'h10,  32'h0002_0003, 32'h0100_0201, 32'd6, 32'h28},
        '{32'h43,  32'h0001_0004, 32'h0100_0200, 32'd4, 32'h50},
        '{32'hF0,  32'h0002_0004, 32'h0100_0201, 32'd4, 32'h100},
        '{32'h200, 32'h0001_0001, 32'h0100_0200, 32'd0, 32'h200},
        '{32'h20,  32'h0000_0005, 32'h0100_0201, 32'd0, 32'h20},
        '{32'h08,  32'h0001_0001, 32'h0100_0203, 32'd0, 32'h08},
        '{32'h31,  32'h0003_0003, 32'h0100_0200, 32'd9, 32'h54}
    };
    localparam string TAGS [NVEC] = '{"R3", "R4", "R10", "R10", "R12", "R8", "R5"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_ready;
    logic [31:0] tx_data;
    logic        rx_valid, rx_ready;
    logic [31:0] rx_data;
    logic        irq;

    logic [31:0] mem [MEMW];
    logic [31:0] tx_log [MEMW];
    int          tx_cnt = 0;
    int          wr_cnt = 0;
    int          rx_cnt = 0;
    int          irq_cnt = 0;
    int          phase = 0;
    logic [31:0] rx_base = '0;
    logic        hold_off = 1'b0;
    logic        stall_mode = 1'b0;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_block_chan #(.MEM_WORDS(MEMW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .irq(irq)
    );

    assign mem_rdata = (mem_addr[31:2] < 30'(MEMW)) ? mem[mem_addr[7:2]] : 32'hDEAD_BEEF;
    assign rx_data   = rx_base + 32'(rx_cnt);

    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            mem[mem_addr[7:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (tx_valid && tx_ready) begin
            tx_log[tx_cnt[5:0]] <= tx_data;
            tx_cnt <= tx_cnt + 1;
        end
        if (rx_valid && rx_ready) rx_cnt <= rx_cnt + 1;
        if (irq) irq_cnt <= irq_cnt + 1;
    end

    always @(negedge clk) begin
        phase    = phase + 1;
        tx_ready = hold_off ? 1'b0 : (stall_mode ? ((phase % 3) != 0) : 1'b1);
        rx_valid = hold_off ? 1'b0 : (stall_mode ? ((phase % 2) != 0) : 1'b1);
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel   = sel;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_logs();
        for (int j = 0; j < MEMW; j++) begin
            mem[j]    = 32'hA000_0000 + 32'(j);
            tx_log[j] = '0;
        end
        tx_cnt  = 0;
        wr_cnt  = 0;
        rx_cnt  = 0;
        irq_cnt = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int n = 0; n < 500; n++) begin
            rd(2'd2, c);
            if (!c[24]) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2, sw;
        clear_logs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, v); check(v == 0, "R1", "addr after reset", v, 0);
        rd(2'd1, v); check(v == 0, "R1", "block after reset", v, 0);
        rd(2'd2, v); check(v == 0, "R1", "ctrl after reset", v, 0);
        check(!irq && !mem_en && !tx_valid && !rx_ready, "R1", "idle outputs",
              {28'b0, irq, mem_en, tx_valid, rx_ready}, 0);

        // table of transfers
        for (int i = 0; i < NVEC; i++) begin
            clear_logs();
            stall_mode = i[0];
            rx_base    = 32'hC000_0000 + (32'(i) << 8);
            wr(2'd0, VECS[i].addr);
            wr(2'd1, VECS[i].blk);
            wr(2'd2, VECS[i].ctrl);
            wait_idle();
            check(irq_cnt == 1, TAGS[i], "irq pulses (R7)", 32'(irq_cnt), 1);
            check(tx_cnt + wr_cnt == int'(VECS[i].words), TAGS[i], "words moved",
                  32'(tx_cnt + wr_cnt), VECS[i].words);
            rd(2'd0, v);
            check(v == VECS[i].end_addr, TAGS[i], "end address (R9)", v, VECS[i].end_addr);
            rd(2'd2, v);
            check(v == (VECS[i].ctrl & ~32'h0100_0000), TAGS[i], "ctrl readback (R7)",
                  v, VECS[i].ctrl & ~32'h0100_0000);
            sw = {2'b00, VECS[i].addr[31:2]};
            for (int k = 0; k < int'(VECS[i].words); k++) begin
                if (VECS[i].ctrl[0])
                    check(tx_log[k] == 32'hA000_0000 + sw + 32'(k), TAGS[i], "tx word order (R3)",
                          tx_log[k], 32'hA000_0000 + sw + 32'(k));
                else
                    check(mem[sw[5:0] + 6'(k)] == rx_base + 32'(k), TAGS[i], "mem write order (R5)",
                          mem[sw[5:0] + 6'(k)], rx_base + 32'(k));
            end
        end
        stall_mode = 1'b0;

        // R2: register readback while idle, and R8: no start bit means no action
        clear_logs();
        wr(2'd0, 32'h1234_5679);
        rd(2'd0, v); check(v == 32'h1234_5679, "R2", "addr readback", v, 32'h1234_5679);
        wr(2'd1, 32'hABCD_0001);
        rd(2'd1, v); check(v == 32'hABCD_0001, "R2", "block readback", v, 32'hABCD_0001);
        wr(2'd2, 32'h0000_0201);
        repeat (2) @(negedge clk);
        rd(2'd2, v); check(v == 32'h0000_0201, "R2", "ctrl readback", v, 32'h0000_0201);
        check(irq_cnt == 0 && tx_cnt == 0, "R8", "no start bit is inert",
              32'(irq_cnt + tx_cnt), 0);
        rd(2'd3, v); check(v == 0, "R2", "unused selector reads zero", v, 0);
        rd(2'd0, v); check(v == 32'h1234_5679, "R4", "no alignment without start", v, 32'h1234_5679);

        // R6/R11: stalled transfer, writes while busy
        clear_logs();
        hold_off = 1'b1;
        wr(2'd0, 32'h0000_0004);
        wr(2'd1, 32'h0001_0003);
        wr(2'd2, 32'h0100_0201);
        repeat (2) @(negedge clk);
        rd(2'd2, v); check(v[24], "R7", "busy set while running", {31'b0, v[24]}, 1);
        #1; v2 = tx_data;
        check(mem_addr == 32'h4, "R6", "stalled mem_addr", mem_addr, 32'h4);
        wr(2'd0, 32'h0000_0080);
        wr(2'd1, 32'h0005_0005);
        rd(2'd0, v); check(v == 32'h4, "R11", "addr write ignored while busy", v, 32'h4);
        rd(2'd1, v); check(v == 32'h0001_0003, "R11", "block write ignored while busy", v, 32'h0001_0003);
        #1;
        check(tx_data == v2 && mem_addr == 32'h4, "R6", "tx_data held while stalled", tx_data, v2);
        check(tx_cnt == 0, "R6", "no word moved while stalled", 32'(tx_cnt), 0);
        hold_off = 1'b0;
        wait_idle();
        rd(2'd0, v); check(v == 32'h10, "R9", "end address after stall", v, 32'h10);
        check(tx_cnt == 3 && irq_cnt == 1, "R3", "stalled transfer completes",
              32'(tx_cnt), 3);
        check(tx_log[0] == 32'hA000_0001, "R3", "first word after stall", tx_log[0], 32'hA000_0001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule